// File: doc/BRIEF.md
# Vector Length Grant Register

This block holds the active vector length of a vector unit. It also works out how many elements a strip-mined loop may process in its next pass. A request carries an unsigned application length (AVL). The block compares it with the maximum vector length (MVL), which the configuration logic supplies. It then stores the granted length and returns that same value as the instruction result.

The grant is not a plain minimum of AVL and MVL. When the remaining work is more than one full vector but less than two, the block grants half of it, rounded down. This keeps the last two passes of the loop about the same size.

The configuration logic can send a reinitialise pulse, which loads MVL into the register. The current length can be read on its own port at any time. A zero flag tells the datapath that no element operations are to take place.

Top module: `vlen_unit`

## Requirements
- R1: When AVL >= 2·MVL, the granted length equals MVL.
- R2: When MVL < AVL < 2·MVL, the granted length is floor(AVL/2).
- R3: When AVL <= MVL, the granted length equals AVL.
- R4: A request accepted at one clock edge updates `vl_o` and `grant_o` with the new grant at that edge. `done_o` is high for exactly that one following cycle. `grant_o` carries the new value, not the old contents of the register.
- R5: 2·MVL is formed with XLEN+1 bits, so it never wraps. With XLEN=32, an all-ones AVL and MVL=0x7FFFFFFF grant 0x7FFFFFFF. An all-ones AVL and MVL=0x80000000 grant 0x7FFFFFFF (the split rule), not MVL.
- R6: A reinitialise pulse loads MVL into `vl_o` at the next edge. If a request arrives in the same cycle, the reinitialise wins: `done_o` stays 0 and `grant_o` keeps its previous value.
- R7: `zero_o` is 1 exactly when `vl_o` is 0.
- R8: After reset, `vl_o`=0, `grant_o`=0, `done_o`=0 and `zero_o`=1.
- R9: With no request and no reinitialise, `vl_o` holds its value and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mvl_i | input | XLEN | Current maximum vector length from the configuration logic |
| reinit_i | input | 1 | Reinitialise pulse: load MVL into the length register |
| req_valid_i | input | 1 | Length request strobe |
| req_avl_i | input | XLEN | Requested application length, unsigned |
| vl_o | output | XLEN | Current active vector length |
| grant_o | output | XLEN | Result of the last accepted request |
| done_o | output | 1 | One-cycle pulse: a request has completed |
| zero_o | output | 1 | Active length is zero |

## Verification
A length request and a reinitialise pulse can arrive in the same cycle. The bench drives both strobes on one edge, with a small AVL and a different MVL. It then expects the register to hold the new MVL, `done_o` to stay low, and `grant_o` to keep the result of the previous request. A table of AVL/MVL pairs probes each side of the MVL and 2·MVL boundaries. Directed cases with MVL near half of the XLEN range show whether the doubled MVL wraps.

// File: rtl/vl_pkg.sv
package vl_pkg;
    localparam int unsigned XLEN_DEFAULT = 32;

    typedef enum logic [1:0] {
        GR_PASS  = 2'd0,
        GR_SPLIT = 2'd1,
        GR_FULL  = 2'd2
    } grant_case_e;
endpackage

// File: rtl/vl_grant_calc.sv
module vl_grant_calc
    import vl_pkg::*;
#(
    parameter int unsigned XLEN = XLEN_DEFAULT
) (
    input  logic [XLEN-1:0] avl_i,
    input  logic [XLEN-1:0] mvl_i,
    output logic [XLEN-1:0] grant_o
);
    localparam int unsigned WIDE = XLEN + 1;

    logic [WIDE-1:0] mvl_twice;
    logic [WIDE-1:0] avl_wide;
    grant_case_e     sel;

    always_comb begin
        // doubled limit kept one bit wider so it cannot wrap
        mvl_twice = {mvl_i, 1'b0};
        avl_wide  = {1'b0, avl_i};
        if (avl_wide >= mvl_twice) begin
            sel = GR_FULL;
        end else if (avl_i > mvl_i) begin
            sel = GR_SPLIT;
        end else begin
            sel = GR_PASS;
        end
        unique case (sel)
            GR_FULL:  grant_o = mvl_i;
            GR_SPLIT: grant_o = avl_i >> 1;
            default:  grant_o = avl_i;
        endcase
    end
endmodule

// File: rtl/vl_zero_detect.sv
module vl_zero_detect #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] len_i,
    output logic            zero_o
);
    always_comb begin
        zero_o = (len_i == '0);
    end
endmodule

// File: rtl/vlen_unit.sv
module vlen_unit
    import vl_pkg::*;
#(
    parameter int unsigned XLEN = XLEN_DEFAULT
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [XLEN-1:0] mvl_i,
    input  logic            reinit_i,
    input  logic            req_valid_i,
    input  logic [XLEN-1:0] req_avl_i,
    output logic [XLEN-1:0] vl_o,
    output logic [XLEN-1:0] grant_o,
    output logic            done_o,
    output logic            zero_o
);
    typedef struct packed {
        logic [XLEN-1:0] vl;
        logic [XLEN-1:0] res;
        logic            done;
    } vl_state_t;

    vl_state_t       st_d, st_q;
    logic [XLEN-1:0] grant_w;

    vl_grant_calc #(.XLEN(XLEN)) u_calc (
        .avl_i   (req_avl_i),
        .mvl_i   (mvl_i),
        .grant_o (grant_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (reinit_i) begin
            // configuration change wins over a concurrent request
            st_d.vl = mvl_i;
        end else if (req_valid_i) begin
            st_d.vl   = grant_w;
            st_d.res  = grant_w;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    vl_zero_detect #(.XLEN(XLEN)) u_zero (
        .len_i  (st_q.vl),
        .zero_o (zero_o)
    );

    assign vl_o    = st_q.vl;
    assign grant_o = st_q.res;
    assign done_o  = st_q.done;
endmodule

// File: rtl/vlen_unit_chk.sv
module vlen_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [XLEN-1:0] mvl_i,
    input logic            reinit_i,
    input logic            req_valid_i,
    input logic [XLEN-1:0] vl_o,
    input logic [XLEN-1:0] grant_o,
    input logic            done_o,
    input logic            zero_o
);
    // R6: reinitialise loads MVL
    p_reinit_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reinit_i |=> (vl_o == $past(mvl_i)));

    // R6: concurrent request is dropped
    p_reinit_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reinit_i |=> !done_o);

    // R4: accepted request completes next cycle
    p_done_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !reinit_i) |=> done_o);

    // R4: result equals the new register value
    p_result_is_new_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (grant_o == vl_o));

    // R1 R2 R3: grant never exceeds MVL
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !reinit_i) |=> (vl_o <= $past(mvl_i)));

    // R9: idle cycles hold the length
    p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_valid_i && !reinit_i) |=> ($stable(vl_o) && !done_o));

    // R7: zero flag only with empty length
    p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o |-> (vl_o == '0));
endmodule

bind vlen_unit vlen_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/vlen_unit_tb.sv
module vlen_unit_tb;
    localparam int unsigned XLEN = 32;
    localparam int NVEC = 14;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic [XLEN-1:0] mvl_i = '0;
    logic            reinit_i = 1'b0;
    logic            req_valid_i = 1'b0;
    logic [XLEN-1:0] req_avl_i = '0;
    logic [XLEN-1:0] vl_o;
    logic [XLEN-1:0] grant_o;
    logic            done_o;
    logic            zero_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #2 clk_i = ~clk_i;

    vlen_unit #(.XLEN(XLEN)) u_dut (.*);

    // {mvl, avl, expected grant}
    localparam logic [3*XLEN-1:0] VECS [NVEC] = '{
        {32'd16, 32'd0,          32'd0},
        {32'd16, 32'd1,          32'd1},
        {32'd16, 32'd16,         32'd16},
        {32'd16, 32'd17,         32'd8},
        {32'd16, 32'd31,         32'd15},
        {32'd16, 32'd32,         32'd16},
        {32'd16, 32'd100,        32'd16},
        {32'd16, 32'hFFFF_FFFF,  32'd16},
        {32'd4,  32'd3,          32'd3},
        {32'd4,  32'd5,          32'd2},
        {32'd4,  32'd7,          32'd3},
        {32'd4,  32'd8,          32'd4},
        {32'd64, 32'd127,        32'd63},
        {32'd64, 32'd64,         32'd64}
    };

    task automatic chk(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string classify(input logic [XLEN-1:0] mvl,
                                       input logic [XLEN-1:0] avl);
        if ({1'b0, avl} >= {mvl, 1'b0}) return "R1";
        else if (avl > mvl) return "R2";
        else return "R3";
    endfunction

    task automatic request(input logic [XLEN-1:0] mvl, input logic [XLEN-1:0] avl);
        @(negedge clk_i);
        mvl_i       = mvl;
        req_avl_i   = avl;
        req_valid_i = 1'b1;
        @(negedge clk_i);
        req_valid_i = 1'b0;
    endtask

    initial begin
        logic [XLEN-1:0] prev_grant;
        repeat (3) @(negedge clk_i);
        // R8 reset state
        chk("R8 vl", vl_o, '0);
        chk("R8 grant", grant_o, '0);
        chk("R8 done", {31'd0, done_o}, 32'd0);
        chk("R7 zero at reset", {31'd0, zero_o}, 32'd1);
        rst_ni = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [XLEN-1:0] m, a, e;
            {m, a, e} = VECS[i];
            request(m, a);
            chk(classify(m, a), vl_o, e);
            chk("R4 grant", grant_o, e);
            chk("R4 done", {31'd0, done_o}, 32'd1);
            chk("R7 zero", {31'd0, zero_o}, {31'd0, (e == 0)});
        end

        // R4 done is a single pulse; R9 idle hold
        @(negedge clk_i);
        chk("R4 done pulse", {31'd0, done_o}, 32'd0);
        repeat (3) @(negedge clk_i);
        chk("R9 hold", vl_o, 32'd64);

        // R5 wide values
        request(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        chk("R5 all-ones", vl_o, 32'h7FFF_FFFF);
        request(32'h8000_0000, 32'hFFFF_FFFF);
        chk("R5 no wrap", vl_o, 32'h7FFF_FFFF);

        // R6 reinitialise alone
        request(32'd8, 32'd0);
        chk("R7 zero set", {31'd0, zero_o}, 32'd1);
        @(negedge clk_i);
        mvl_i = 32'd12; reinit_i = 1'b1;
        @(negedge clk_i);
        reinit_i = 1'b0;
        chk("R6 reinit", vl_o, 32'd12);
        chk("R7 zero clear", {31'd0, zero_o}, 32'd0);

        // R6 reinitialise together with a request
        prev_grant = grant_o;
        @(negedge clk_i);
        mvl_i = 32'd20; reinit_i = 1'b1; req_valid_i = 1'b1; req_avl_i = 32'd3;
        @(negedge clk_i);
        reinit_i = 1'b0; req_valid_i = 1'b0;
        chk("R6 collide vl", vl_o, 32'd20);
        chk("R6 collide done", {31'd0, done_o}, 32'd0);
        chk("R6 collide grant", grant_o, prev_grant);

        // R8 reset mid-run
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk("R8 re-reset", vl_o, '0);
        rst_ni = 1'b1;

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule